// File: doc/BRIEF.md
# Guarded Control Register Write Sequencer

This block holds the single 8-bit control register that a serial-bus slave exposes at address FFFFh. A two-wire bit engine in front of it decodes the bus. It reports byte-level events as one-cycle pulses: start, stop, an address phase (with an address-match flag and a read/write flag), each data byte together with its index inside the write, and a read-byte request. The block answers each data byte with an ACK or NACK decision one cycle later and returns the register contents on a read.

The register mixes two volatile enable latches with nonvolatile fields: watchdog period select, three block-protect bits and a sticky write-protect enable. The nonvolatile fields can only be changed at the end of a three-write unlock sequence. A nonvolatile store is modelled as a busy interval of `NV_CYCLES` clocks. Every write waits in a pending slot until the bus stop condition, so a write that is aborted, restarted or cut off by the supervisor reset leaves no trace. A hardware protect pin, combined with the protect-enable bit, freezes the block-protect bits and prevents the enable from being cleared.

The bus-side sequencer is a five-state machine:
- `ST_IDLE`: waiting for an address phase.
- `ST_WR_WAIT`: addressed for write, waiting for the first byte.
- `ST_WR_HELD`: one accepted byte is pending.
- `ST_WR_DEAD`: the write was refused or aborted.
- `ST_RD_ONE`: addressed for read, one byte allowed.

Its transitions are:
- IDLE→WR_WAIT on a matching write address, and IDLE→RD_ONE on a matching read address.
- WR_WAIT→HELD on an accepted first byte, and WR_WAIT→DEAD on a refused byte.
- HELD→DEAD on any further byte.
- HELD→IDLE on stop, which commits the pending byte.
- WR_WAIT, DEAD and RD_ONE→IDLE on stop.
- RD_ONE→IDLE on a read request.
- Any state→IDLE on start or on supervisor reset.

Top module: `ctrl_reg_guard`

## Requirements
- R1: After `rst_n` low, `reg_q` equals `NV_INIT` restricted to bits 7..3 and 0 (default 00h), both enable latches are clear, and `nv_busy`, `ack_valid` and `rd_valid` are low.
- R2: Register layout, bit 7 down to bit 0: protect-enable, period-select high, period-select low, block-protect 1, block-protect 0, register-write latch, write latch, block-protect 2. While the write latch (bit 1) is clear, only the byte 02h is accepted. Any other byte is NACKed and changes nothing.
- R3: Byte 02h sets the write latch. Byte 06h with the write latch set sets both latches. Byte 00h with the write latch set clears the write latch only. None of these starts a busy interval.
- R4: With both latches set, a byte with bit 1 = 1 and bit 2 = 0 is a nonvolatile store. It copies data bits 7..3 and 0 into the register, clears bit 2, keeps bit 1, and drives `nv_busy` high for `NV_CYCLES` clocks starting right after the stop.
- R5: With both latches set, a byte with bits 1 and 2 both set is acknowledged and changes no bit of the register.
- R6: An accepted byte takes effect only at the clock of the following stop. A start before that stop discards it.
- R7: Only a first byte (index 0) can be accepted. A further byte in the same write is NACKed, and the whole write is then dropped at stop.
- R8: While `wp_pin` and bit 7 are both high, a nonvolatile store keeps bits 4, 3 and 0 and keeps bit 7 set; only the period-select bits follow the data.
- R9: A data byte arriving while `nv_busy` is high is NACKed and ignored.
- R10: While `sup_reset` is high, writes are refused and the bus sequencer returns to idle, dropping any pending byte.
- R11: A read access returns exactly one byte: `rd_valid` pulses one cycle after the first read request, with `rd_data` equal to the register. A second request in the same access gets no response. Reads do not disturb the latches.
- R12: `ack_valid` pulses one cycle after a data byte only while the block is addressed for write. A byte matching none of the recognised patterns is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| sup_reset | input | 1 | Supervisor reset active; blocks bus access |
| wp_pin | input | 1 | Hardware write-protect pin level |
| ev_start | input | 1 | Bus start condition pulse |
| ev_stop | input | 1 | Bus stop condition pulse |
| ev_addr | input | 1 | Address phase complete pulse |
| addr_hit | input | 1 | Address phase targeted this register |
| addr_rnw | input | 1 | Address phase direction, 1 = read |
| ev_data | input | 1 | Write data byte received pulse |
| data_idx | input | IDX_W | Index of the byte within the write |
| data_byte | input | 8 | Received data byte |
| ev_read | input | 1 | Read byte request pulse |
| ack_valid | output | 1 | ACK decision valid |
| ack | output | 1 | 1 = ACK, 0 = NACK |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Register value returned on read |
| reg_q | output | 8 | Current register contents |
| nv_busy | output | 1 | Nonvolatile store in progress |

## Verification
The hardest situation to reach is a nonvolatile store under hardware protection. The bench has to walk the full unlock path twice: first to store a value with the protect-enable set, then again with `wp_pin` high, so that a zero-valued store must leave the protect-enable and block-protect bits untouched while the period bits clear. The vector table chains these writes in order so that each row starts from the latch state left by the previous one. Directed tests then cover the remaining hard cases. One issues a write while the busy counter from a store is still running. One checks a read placed between unlock steps, followed by a store that succeeds only if the register-write latch survived. One pulses the supervisor reset between an accepted byte and its stop.

// File: rtl/ctrl_guard_pkg.sv
package ctrl_guard_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_WAIT,
        ST_WR_HELD,
        ST_WR_DEAD,
        ST_RD_ONE
    } bus_state_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_SET_WEL,
        ACT_SET_BOTH,
        ACT_CLR_WEL,
        ACT_NV_STORE,
        ACT_HOLD
    } reg_act_e;

    localparam int REG_W  = 8;
    localparam int B_PEN  = 7;
    localparam int B_BP1  = 4;
    localparam int B_BP0  = 3;
    localparam int B_RLAT = 2;
    localparam int B_WLAT = 1;
    localparam int B_BP2  = 0;

    localparam logic [REG_W-1:0] CODE_SET_WEL  = 8'h02;
    localparam logic [REG_W-1:0] CODE_SET_BOTH = 8'h06;
    localparam logic [REG_W-1:0] CODE_CLR_WEL  = 8'h00;
    localparam logic [REG_W-1:0] NV_MASK       = 8'hF9;

endpackage

// File: rtl/ctrl_reg_decode.sv
module ctrl_reg_decode
    import ctrl_guard_pkg::*;
(
    input  logic [REG_W-1:0] data_byte,
    input  logic             wel,
    input  logic             rwel,
    input  logic             busy,
    input  logic             sup_reset,
    input  logic             first_byte,
    output logic             accept,
    output reg_act_e         act
);

    always_comb begin
        act = ACT_NONE;
        if (!busy && !sup_reset && first_byte) begin
            if (wel && rwel && data_byte[B_WLAT]) begin
                act = data_byte[B_RLAT] ? ACT_HOLD : ACT_NV_STORE;
            end else if (data_byte == CODE_SET_WEL) begin
                act = ACT_SET_WEL;
            end else if (wel && data_byte == CODE_SET_BOTH) begin
                act = ACT_SET_BOTH;
            end else if (wel && data_byte == CODE_CLR_WEL) begin
                act = ACT_CLR_WEL;
            end
        end
        accept = (act != ACT_NONE);
    end

endmodule

// File: rtl/ctrl_reg_fsm.sv
module ctrl_reg_fsm
    import ctrl_guard_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_reset,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_addr,
    input  logic             addr_hit,
    input  logic             addr_rnw,
    input  logic             ev_data,
    input  logic             ev_read,
    input  logic [REG_W-1:0] data_byte,
    input  logic             accept,
    input  reg_act_e         act_in,
    input  logic [REG_W-1:0] reg_q,
    output logic             ack_valid,
    output logic             ack,
    output logic             rd_valid,
    output logic [REG_W-1:0] rd_data,
    output logic             commit,
    output reg_act_e         pend_act,
    output logic [REG_W-1:0] pend_data
);

    bus_state_e state, state_nx;
    logic       wr_phase;
    logic       quiet;

    assign quiet    = sup_reset || ev_start;
    assign wr_phase = (state == ST_WR_WAIT) || (state == ST_WR_HELD) || (state == ST_WR_DEAD);
    assign commit   = !sup_reset && ev_stop && (state == ST_WR_HELD);

    always_comb begin
        state_nx = state;
        if (quiet) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ev_addr && addr_hit) state_nx = addr_rnw ? ST_RD_ONE : ST_WR_WAIT;
                end
                ST_WR_WAIT: begin
                    if (ev_stop)      state_nx = ST_IDLE;
                    else if (ev_data) state_nx = accept ? ST_WR_HELD : ST_WR_DEAD;
                end
                ST_WR_HELD: begin
                    if (ev_stop)      state_nx = ST_IDLE;
                    else if (ev_data) state_nx = ST_WR_DEAD;
                end
                ST_WR_DEAD: begin
                    if (ev_stop) state_nx = ST_IDLE;
                end
                ST_RD_ONE: begin
                    if (ev_read || ev_stop) state_nx = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack       <= 1'b0;
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            pend_act  <= ACT_NONE;
            pend_data <= '0;
        end else begin
            ack_valid <= ev_data && wr_phase && !ev_start;
            ack       <= ev_data && !quiet && (state == ST_WR_WAIT) && accept;
            rd_valid  <= ev_read && !quiet && (state == ST_RD_ONE);
            if (ev_read && !quiet && state == ST_RD_ONE) rd_data <= reg_q;
            if (ev_data && !quiet && state == ST_WR_WAIT && accept) begin
                pend_act  <= act_in;
                pend_data <= data_byte;
            end
        end
    end

endmodule

// File: rtl/ctrl_reg_store.sv
module ctrl_reg_store
    import ctrl_guard_pkg::*;
#(
    parameter int               NV_CYCLES = 200,
    parameter logic [REG_W-1:0] NV_INIT   = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_pin,
    input  logic             commit,
    input  reg_act_e         act,
    input  logic [REG_W-1:0] data,
    output logic [REG_W-1:0] reg_q,
    output logic             wel,
    output logic             rwel,
    output logic             busy
);

    localparam int CNT_W = $clog2(NV_CYCLES + 1);

    logic [REG_W-1:0] nv_bits;
    logic [REG_W-1:0] nv_next;
    logic [CNT_W-1:0] cnt;
    logic             locked;

    assign locked = wp_pin && nv_bits[B_PEN];
    assign busy   = (cnt != '0);

    always_comb begin
        nv_next = data & NV_MASK;
        if (locked) begin
            nv_next[B_PEN] = 1'b1;
            nv_next[B_BP1] = nv_bits[B_BP1];
            nv_next[B_BP0] = nv_bits[B_BP0];
            nv_next[B_BP2] = nv_bits[B_BP2];
        end
    end

    always_comb begin
        reg_q         = nv_bits;
        reg_q[B_RLAT] = rwel;
        reg_q[B_WLAT] = wel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_bits <= NV_INIT & NV_MASK;
            wel     <= 1'b0;
            rwel    <= 1'b0;
            cnt     <= '0;
        end else begin
            if (busy) cnt <= cnt - 1'b1;
            if (commit) begin
                unique case (act)
                    ACT_SET_WEL:  wel <= 1'b1;
                    ACT_SET_BOTH: begin
                        wel  <= 1'b1;
                        rwel <= 1'b1;
                    end
                    ACT_CLR_WEL:  wel <= 1'b0;
                    ACT_NV_STORE: begin
                        nv_bits <= nv_next;
                        rwel    <= 1'b0;
                        cnt     <= CNT_W'(NV_CYCLES);
                    end
                    ACT_HOLD, ACT_NONE: ;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/ctrl_reg_guard.sv
module ctrl_reg_guard
    import ctrl_guard_pkg::*;
#(
    parameter int               IDX_W     = 4,
    parameter int               NV_CYCLES = 200,
    parameter logic [REG_W-1:0] NV_INIT   = 8'h00
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_reset,
    input  logic             wp_pin,
    input  logic             ev_start,
    input  logic             ev_stop,
    input  logic             ev_addr,
    input  logic             addr_hit,
    input  logic             addr_rnw,
    input  logic             ev_data,
    input  logic [IDX_W-1:0] data_idx,
    input  logic [REG_W-1:0] data_byte,
    input  logic             ev_read,
    output logic             ack_valid,
    output logic             ack,
    output logic             rd_valid,
    output logic [REG_W-1:0] rd_data,
    output logic [REG_W-1:0] reg_q,
    output logic             nv_busy
);

    logic             accept;
    reg_act_e         dec_act;
    reg_act_e         pend_act;
    logic [REG_W-1:0] pend_data;
    logic             commit;
    logic             wel;
    logic             rwel;

    ctrl_reg_decode u_decode (
        .data_byte  (data_byte),
        .wel        (wel),
        .rwel       (rwel),
        .busy       (nv_busy),
        .sup_reset  (sup_reset),
        .first_byte (data_idx == '0),
        .accept     (accept),
        .act        (dec_act)
    );

    ctrl_reg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sup_reset (sup_reset),
        .ev_start  (ev_start),
        .ev_stop   (ev_stop),
        .ev_addr   (ev_addr),
        .addr_hit  (addr_hit),
        .addr_rnw  (addr_rnw),
        .ev_data   (ev_data),
        .ev_read   (ev_read),
        .data_byte (data_byte),
        .accept    (accept),
        .act_in    (dec_act),
        .reg_q     (reg_q),
        .ack_valid (ack_valid),
        .ack       (ack),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .commit    (commit),
        .pend_act  (pend_act),
        .pend_data (pend_data)
    );

    ctrl_reg_store #(
        .NV_CYCLES (NV_CYCLES),
        .NV_INIT   (NV_INIT)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wp_pin (wp_pin),
        .commit (commit),
        .act    (pend_act),
        .data   (pend_data),
        .reg_q  (reg_q),
        .wel    (wel),
        .rwel   (rwel),
        .busy   (nv_busy)
    );

endmodule

// File: rtl/ctrl_reg_guard_chk.sv
module ctrl_reg_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sup_reset,
    input logic       wp_pin,
    input logic       ev_data,
    input logic       ev_read,
    input logic       ack_valid,
    input logic       ack,
    input logic       rd_valid,
    input logic [7:0] rd_data,
    input logic [7:0] reg_q,
    input logic       nv_busy
);

    // R12
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(ev_data));

    // R9
    busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack) |-> !$past(nv_busy));

    // R10
    supv_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack) |-> !$past(sup_reset));

    // R8
    pen_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pin && reg_q[7]) |=> reg_q[7]);

    // R8
    bp_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_pin && reg_q[7]) |=> ($stable(reg_q[4:3]) && $stable(reg_q[0])));

    // R4
    rlat_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> !reg_q[2]);

    // R11
    rd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(ev_read));

    // R11
    rd_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data == $past(reg_q)));

endmodule

bind ctrl_reg_guard ctrl_reg_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sup_reset (sup_reset),
    .wp_pin    (wp_pin),
    .ev_data   (ev_data),
    .ev_read   (ev_read),
    .ack_valid (ack_valid),
    .ack       (ack),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .reg_q     (reg_q),
    .nv_busy   (nv_busy)
);

// File: tb/ctrl_reg_guard_tb.sv
`timescale 1ns/1ps
module ctrl_reg_guard_tb;

    localparam int IDX_W = 4;
    localparam int NVC   = 200;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sup_reset = 1'b0, wp_pin = 1'b0;
    logic             ev_start = 1'b0, ev_stop = 1'b0, ev_addr = 1'b0;
    logic             addr_hit = 1'b0, addr_rnw = 1'b0;
    logic             ev_data = 1'b0, ev_read = 1'b0;
    logic [IDX_W-1:0] data_idx = '0;
    logic [7:0]       data_byte = '0;
    logic             ack_valid, ack, rd_valid, nv_busy;
    logic [7:0]       rd_data, reg_q;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ctrl_reg_guard #(.IDX_W(IDX_W), .NV_CYCLES(NVC), .NV_INIT(8'h00)) u_dut (
        .clk(clk), .rst_n(rst_n), .sup_reset(sup_reset), .wp_pin(wp_pin),
        .ev_start(ev_start), .ev_stop(ev_stop), .ev_addr(ev_addr),
        .addr_hit(addr_hit), .addr_rnw(addr_rnw), .ev_data(ev_data),
        .data_idx(data_idx), .data_byte(data_byte), .ev_read(ev_read),
        .ack_valid(ack_valid), .ack(ack), .rd_valid(rd_valid),
        .rd_data(rd_data), .reg_q(reg_q), .nv_busy(nv_busy)
    );

    // {wp, data, expected ack, expected register after stop}
    localparam logic [17:0] VEC [0:12] = '{
        {1'b0, 8'h06, 1'b0, 8'h00},  // R2 06h with latch clear
        {1'b0, 8'h02, 1'b1, 8'h02},  // R3 set write latch
        {1'b0, 8'h06, 1'b1, 8'h06},  // R3 set both
        {1'b0, 8'h06, 1'b1, 8'h06},  // R5 hold
        {1'b0, 8'hF3, 1'b1, 8'hF3},  // R4 store
        {1'b0, 8'h06, 1'b1, 8'hF7},  // R3
        {1'b1, 8'h02, 1'b1, 8'h93},  // R8 protected store
        {1'b0, 8'h06, 1'b1, 8'h97},  // R3
        {1'b0, 8'h02, 1'b1, 8'h02},  // R4 store zeros
        {1'b0, 8'h00, 1'b1, 8'h00},  // R3 clear write latch
        {1'b0, 8'h00, 1'b0, 8'h00},  // R2 00h with latch clear
        {1'b0, 8'h02, 1'b1, 8'h02},  // R3
        {1'b0, 8'h5A, 1'b0, 8'h02}   // R12 unknown pattern
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); ev_start = 1'b1; @(negedge clk); ev_start = 1'b0;
    endtask
    task automatic pulse_stop();
        @(negedge clk); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
    endtask
    task automatic pulse_addr(input logic hit, input logic rnw);
        @(negedge clk); ev_addr = 1'b1; addr_hit = hit; addr_rnw = rnw;
        @(negedge clk); ev_addr = 1'b0;
    endtask
    task automatic pulse_data(input logic [7:0] b, input logic [IDX_W-1:0] idx);
        @(negedge clk); ev_data = 1'b1; data_byte = b; data_idx = idx;
        @(negedge clk); ev_data = 1'b0;
    endtask
    task automatic pulse_read();
        @(negedge clk); ev_read = 1'b1; @(negedge clk); ev_read = 1'b0;
    endtask
    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] av;
        logic       ak;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reg_q", reg_q, 8'h00);
        chk("R1 busy", {7'd0, nv_busy}, 8'h00);
        chk("R1 ack_valid", {7'd0, ack_valid}, 8'h00);
        chk("R1 rd_valid", {7'd0, rd_valid}, 8'h00);

        for (int i = 0; i < 13; i++) begin
            wp_pin = VEC[i][17];
            pulse_start();
            pulse_addr(1'b1, 1'b0);
            pulse_data(VEC[i][16:9], '0);
            av = {6'd0, ack_valid, ack};
            pulse_stop();
            wait_idle();
            chk($sformatf("R2/R3/R4/R5/R8/R12 vec%0d ack", i), av, {6'd0, 1'b1, VEC[i][8]});
            chk($sformatf("R2/R3/R4/R5/R8/R12 vec%0d reg", i), reg_q, VEC[i][7:0]);
            wp_pin = 1'b0;
        end

        // R7 second byte aborts
        pulse_start(); pulse_addr(1'b1, 1'b0);
        pulse_data(8'h06, 0);
        chk("R7 first ack", {7'd0, ack}, 8'h01);
        pulse_data(8'h06, 1);
        chk("R7 second nack", {6'd0, ack_valid, ack}, 8'h02);
        pulse_stop();
        chk("R7 no effect", reg_q, 8'h02);

        // R6 repeated start discards, and no change before stop
        pulse_start(); pulse_addr(1'b1, 1'b0);
        pulse_data(8'h06, 0);
        chk("R6 before stop", reg_q, 8'h02);
        pulse_start(); pulse_stop();
        chk("R6 restart discards", reg_q, 8'h02);

        // R11 read between unlock steps
        pulse_start(); pulse_addr(1'b1, 1'b0); pulse_data(8'h06, 0); pulse_stop();
        chk("R3 set both", reg_q, 8'h06);
        pulse_start(); pulse_addr(1'b1, 1'b1);
        pulse_read();
        chk("R11 rd_valid", {7'd0, rd_valid}, 8'h01);
        chk("R11 rd_data", rd_data, 8'h06);
        pulse_read();
        chk("R11 single byte", {7'd0, rd_valid}, 8'h00);
        pulse_stop();
        pulse_start(); pulse_addr(1'b1, 1'b0); pulse_data(8'h2A, 0);
        chk("R11 store acked after read", {7'd0, ack}, 8'h01);
        @(negedge clk); ev_stop = 1'b1; @(negedge clk); ev_stop = 1'b0;
        chk("R4 busy after stop", {7'd0, nv_busy}, 8'h01);
        chk("R4 stored", reg_q, 8'h2A);

        // R9 write while busy
        pulse_start(); pulse_addr(1'b1, 1'b0);
        pulse_data(8'h00, 0);
        chk("R9 busy nack", {6'd0, ack_valid, ack}, 8'h02);
        pulse_stop();
        wait_idle();
        chk("R9 no effect", reg_q, 8'h2A);

        // R10 supervisor reset blocks writes
        sup_reset = 1'b1;
        pulse_start(); pulse_addr(1'b1, 1'b0); pulse_data(8'h00, 0);
        ak = ack;
        pulse_stop();
        chk("R10 refused", {7'd0, ak}, 8'h00);
        sup_reset = 1'b0;
        chk("R10 unchanged", reg_q, 8'h2A);
        pulse_start(); pulse_addr(1'b1, 1'b0); pulse_data(8'h00, 0);
        chk("R10 accepted before cut", {7'd0, ack}, 8'h01);
        @(negedge clk); sup_reset = 1'b1; @(negedge clk); sup_reset = 1'b0;
        pulse_stop();
        chk("R10 pending dropped", reg_q, 8'h2A);

        // R12 not addressed: no response
        pulse_start(); pulse_addr(1'b0, 1'b0); pulse_data(8'h00, 0);
        chk("R12 no ack_valid", {7'd0, ack_valid}, 8'h00);
        pulse_stop();
        chk("R12 unchanged", reg_q, 8'h2A);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule